// File: doc/BRIEF.md
# Serial-Addressed Octal Converter Register Controller

This block is the digital control core of an eight-channel converter. A host writes it through a three-wire serial port made of a serial clock, a data input and a combined select/load strobe. While the strobe is low, each accepted rising serial clock edge moves one bit into a 16-bit shift register. When the strobe rises, the top four bits of that register are read as a command address. Depending on the address, the block loads the code that follows into one channel, loads it into all eight channels, does nothing, or puts the device to sleep.

The serial output carries the last bit of the shift register. Several devices can therefore be chained into one long shift path, and they all update on the same strobe edge. The serial pins are sampled by a fast system clock through synchronizers, so the serial clock is never used as a clock. An active-low asynchronous clear wipes the shift register and every channel code. The clear is released through a reset synchronizer.

Top module: `dac_octal_ctrl`

## Requirements
- R1: A command word has 16 bits, sent most significant bit first. Bits 15:12 hold the address. The next CODE_W bits (bits 11:2 for the default CODE_W of 10) hold the channel code. The remaining low bits are padding and are ignored.
- R2: A bit is accepted only on a rising edge of `sck` while `cs_ld` is low. Edges on `sck` while `cs_ld` is high leave the shift register unchanged.
- R3: A rising edge of `cs_ld` decodes whatever the shift register holds at that moment, even if fewer than 16 bits were clocked in during that frame.
- R4: Addresses 1 to 8 load the code into channel index address-1. That channel's code appears at `codes[idx*CODE_W +: CODE_W]`, and all other channels keep their codes.
- R5: Address 0 and addresses 9 through 13 change no channel code.
- R6: Address 15 loads the same code into all eight channels.
- R7: Address 14 sets `asleep` to 1. The code field of that word is ignored, and all channel codes are kept while the device is asleep.
- R8: A load to any address other than 14, including the no-change addresses, clears `asleep`.
- R9: `dout` shows the bit that was accepted 16 accepted serial edges earlier. It changes within a few system clocks after each accepted edge and stays stable until the next one.
- R10: While `clr_n` is low, the shift register and all channel codes are held at zero. The synchronous `rst` zeroes these and also clears `asleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear of the shift register and the codes |
| sck | input | 1 | Serial clock |
| din | input | 1 | Serial data input |
| cs_ld | input | 1 | Select while low; a rising edge loads |
| dout | output | 1 | Shift register output, used for chaining |
| asleep | output | 1 | Sleep status |
| codes | output | 8*CODE_W | Channel codes, channel k at bits k*CODE_W upward |

## Verification
A shift register that slips by one position shows up at `dout`. When a second word is clocked in, each bit of `dout` is compared against the first word, so a slip fails on the first mismatched edge. A wrong decode puts a code into the wrong channel, or changes a channel that should have been left alone. This is visible on `codes` a few system clocks after the strobe rises, and all eight channels are compared after every frame. A stuck sleep flag, or one that is not cleared, shows on `asleep` after the next frame.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 4;
    localparam int N_CH   = 8;
    localparam int CH_W   = $clog2(N_CH);

    localparam logic [ADDR_W-1:0] ADDR_SLEEP = 4'hE;
    localparam logic [ADDR_W-1:0] ADDR_ALL   = 4'hF;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_ONE,
        CMD_ALL,
        CMD_SLEEP
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e       kind;
        logic [CH_W-1:0] ch;
    } cmd_t;

    function automatic cmd_t decode_addr(input logic [ADDR_W-1:0] a);
        cmd_t c;
        c.kind = CMD_NOP;
        c.ch   = '0;
        if (a == ADDR_SLEEP) begin
            c.kind = CMD_SLEEP;
        end else if (a == ADDR_ALL) begin
            c.kind = CMD_ALL;
        end else if (a >= 4'd1 && a <= 4'(N_CH)) begin
            c.kind = CMD_ONE;
            c.ch   = CH_W'(a - 4'd1);
        end
        return c;
    endfunction

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] level
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= pin;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign level = pipe[STAGES-1];
endmodule

// File: rtl/dac_clr_sync.sv
module dac_clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic clr_active
);
    logic [STAGES-1:0] hold;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) hold <= '1;
        else        hold <= hold << 1;
    end

    assign clr_active = hold[STAGES-1];
endmodule

// File: rtl/dac_shift_front.sv
module dac_shift_front
    import dac_ctrl_pkg::*;
#(
    parameter int KEEP_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              sck_lvl,
    input  logic              cs_lvl,
    input  logic              din_lvl,
    output logic [KEEP_W-1:0] word_hi,
    output logic              load_stb,
    output logic              dout
);
    logic [WORD_W-1:0] sr;
    logic              sck_d, cs_d;
    logic              shift_en;

    assign shift_en = sck_lvl & ~sck_d & ~cs_lvl;
    assign load_stb = cs_lvl & ~cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_lvl;
            cs_d  <= cs_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (wipe)          sr <= '0;
        else if (shift_en) sr <= {sr[WORD_W-2:0], din_lvl};
    end

    assign word_hi = sr[WORD_W-1 -: KEEP_W];
    assign dout    = sr[WORD_W-1];

    AST_SR_HOLD_OFF_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !wipe) |=> $stable(sr)); // R2

    AST_SR_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !wipe) |=> (sr[WORD_W-1:1] == $past(sr[WORD_W-2:0]))); // R9
endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank
    import dac_ctrl_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wipe,
    input  logic                     load_stb,
    input  logic [ADDR_W+CODE_W-1:0] word_hi,
    output logic [N_CH*CODE_W-1:0]   codes,
    output logic                     asleep
);
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code_in;
    cmd_t              cmd;
    logic [CODE_W-1:0] code_q [N_CH];

    assign addr    = word_hi[ADDR_W+CODE_W-1 -: ADDR_W];
    assign code_in = word_hi[CODE_W-1:0];
    assign cmd     = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst)           asleep <= 1'b0;
        else if (load_stb) asleep <= (cmd.kind == CMD_SLEEP);
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (wipe)
                code_q[i] <= '0;
            else if (load_stb && (cmd.kind == CMD_ALL ||
                     (cmd.kind == CMD_ONE && cmd.ch == CH_W'(i))))
                code_q[i] <= code_in;
        end
        assign codes[i*CODE_W +: CODE_W] = code_q[i];

        AST_KEEP_UNADDRESSED: assert property (@(posedge clk) disable iff (rst)
            (!wipe && !(load_stb && (addr == 4'(i+1) || addr == ADDR_ALL)))
            |=> $stable(code_q[i])); // R5

        AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (rst)
            (load_stb && !wipe && addr == 4'(i+1)) |=> (code_q[i] == $past(code_in))); // R4

        AST_BCAST_LOAD: assert property (@(posedge clk) disable iff (rst)
            (load_stb && !wipe && addr == ADDR_ALL) |=> (code_q[i] == $past(code_in))); // R6

        AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (rst)
            wipe |=> (code_q[i] == '0)); // R10
    end

    AST_SLEEP_ENTER: assert property (@(posedge clk) disable iff (rst)
        (load_stb && addr == ADDR_SLEEP) |=> asleep); // R7

    AST_WAKE_ANY: assert property (@(posedge clk) disable iff (rst)
        (load_stb && addr != ADDR_SLEEP) |=> !asleep); // R8
endmodule

// File: rtl/dac_octal_ctrl.sv
module dac_octal_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr_n,
    input  logic                   sck,
    input  logic                   din,
    input  logic                   cs_ld,
    output logic                   dout,
    output logic                   asleep,
    output logic [N_CH*CODE_W-1:0] codes
);
    localparam int KEEP_W = ADDR_W + CODE_W;

    logic [2:0]        pin_lvl;
    logic              clr_active, wipe, load_stb;
    logic [KEEP_W-1:0] word_hi;

    dac_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) i_pins (
        .clk  (clk),
        .rst  (rst),
        .pin  ({din, cs_ld, sck}),
        .level(pin_lvl)
    );

    dac_clr_sync #(.STAGES(SYNC_STAGES)) i_clr (
        .clk       (clk),
        .clr_n     (clr_n),
        .clr_active(clr_active)
    );

    assign wipe = rst | clr_active;

    dac_shift_front #(.KEEP_W(KEEP_W)) i_front (
        .clk     (clk),
        .rst     (rst),
        .wipe    (wipe),
        .sck_lvl (pin_lvl[0]),
        .cs_lvl  (pin_lvl[1]),
        .din_lvl (pin_lvl[2]),
        .word_hi (word_hi),
        .load_stb(load_stb),
        .dout    (dout)
    );

    dac_code_bank #(.CODE_W(CODE_W)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .wipe    (wipe),
        .load_stb(load_stb),
        .word_hi (word_hi),
        .codes   (codes),
        .asleep  (asleep)
    );
endmodule

// File: tb/test_dac_octal_ctrl.sv
`timescale 1ns/1ps
module test_dac_octal_ctrl;
    localparam int CW = 10;
    localparam int NC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_n = 1'b1;
    logic sck = 1'b0;
    logic din = 1'b0;
    logic cs_ld = 1'b1;
    logic dout, asleep;
    logic [NC*CW-1:0] codes;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0]   m_sr = '0;
    logic [CW-1:0] m_code [NC];
    logic          m_sleep = 1'b0;
    bit            watch_dout = 0;

    always #5 clk = ~clk;

    dac_octal_ctrl #(.CODE_W(CW)) i_dac_octal_ctrl (
        .clk(clk), .rst(rst), .clr_n(clr_n), .sck(sck), .din(din),
        .cs_ld(cs_ld), .dout(dout), .asleep(asleep), .codes(codes)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < NC; k++)
            chk(req, int'(codes[k*CW +: CW]), int'(m_code[k]));
        chk(req, int'(asleep), int'(m_sleep));
    endtask

    task automatic model_load();
        logic [3:0]    a;
        logic [CW-1:0] c;
        a = m_sr[15:12];
        c = m_sr[11 -: CW];
        m_sleep = (a == 4'hE);
        if (a >= 4'd1 && a <= 4'd8) m_code[a-1] = c;
        if (a == 4'hF) for (int k = 0; k < NC; k++) m_code[k] = c;
    endtask

    task automatic send_bit(input logic b);
        din = b;
        tick(4);
        sck = 1'b1;
        tick(4);
        if (!cs_ld) m_sr = {m_sr[14:0], b};
        if (watch_dout) chk("R9 dout chain", int'(dout), int'(m_sr[15]));
        sck = 1'b0;
    endtask

    task automatic frame(input logic [15:0] w, input int nbits);
        cs_ld = 1'b0;
        tick(4);
        for (int k = 15; k > 15 - nbits; k--) send_bit(w[k]);
        tick(4);
        cs_ld = 1'b1;
        tick(8);
        model_load();
    endtask

    function automatic logic [15:0] mk(input logic [3:0] a, input logic [CW-1:0] c);
        return {a, c, 2'b11};
    endfunction

    task automatic t_reset();
        chk("R10 reset dout", int'(dout), 0);
        check_all("R10 reset state");
    endtask

    task automatic t_single();
        for (int k = 1; k <= NC; k++) begin
            frame(mk(4'(k), CW'(k * 97 + 3)), 16);
            check_all("R4 single channel load");
        end
        frame(mk(4'd2, 10'h201), 16);
        check_all("R1 msb-first code field");
    endtask

    task automatic t_nop();
        frame(mk(4'd0, 10'h3FF), 16);
        check_all("R5 address 0");
        for (int a = 9; a <= 13; a++) begin
            frame(mk(4'(a), 10'h155), 16);
            check_all("R5 no-change address");
        end
    endtask

    task automatic t_bcast();
        frame(mk(4'hF, 10'h2AA), 16);
        check_all("R6 broadcast");
        frame(mk(4'd5, 10'h011), 16);
        check_all("R4 after broadcast");
    endtask

    task automatic t_sleep_wake();
        frame(mk(4'hE, 10'h3C3), 16);
        chk("R7 asleep set", int'(asleep), 1);
        check_all("R7 codes kept in sleep");
        frame(mk(4'd12, 10'h000), 16);
        chk("R8 wake on no-change", int'(asleep), 0);
        check_all("R8 codes after wake");
        frame(mk(4'hE, 10'h000), 16);
        frame(mk(4'd3, 10'h0F0), 16);
        chk("R8 wake on load", int'(asleep), 0);
        check_all("R8 load while waking");
    endtask

    task automatic t_ignore_sck();
        frame(mk(4'd3, 10'h3FF), 16);
        for (int k = 0; k < 8; k++) send_bit(1'b1);
        chk("R2 dout after ignored edges", int'(dout), int'(m_sr[15]));
        frame(16'h0000, 0);
        check_all("R2 shift reg unchanged");
    endtask

    task automatic t_short();
        frame(mk(4'd1, 10'h2F0), 16);
        frame(16'h5000, 4);
        check_all("R3 short frame decode");
        frame(16'hF000, 4);
        check_all("R3 second short frame");
    endtask

    task automatic t_chain();
        frame(16'hA5C3, 16);
        watch_dout = 1;
        frame(mk(4'd7, 10'h0AB), 16);
        watch_dout = 0;
        check_all("R9 second word applied");
    endtask

    task automatic t_clear();
        frame(mk(4'hF, 10'h1E1), 16);
        tick(2);
        clr_n = 1'b0;
        tick(3);
        clr_n = 1'b1;
        tick(6);
        m_sr = '0;
        for (int k = 0; k < NC; k++) m_code[k] = '0;
        check_all("R10 clear zeroes codes");
        chk("R10 clear zeroes dout", int'(dout), 0);
        frame(mk(4'd8, 10'h3A5), 16);
        check_all("R10 usable after clear");
    endtask

    initial begin
        for (int k = 0; k < NC; k++) m_code[k] = '0;
        tick(4);
        rst = 1'b0;
        tick(4);
        t_reset();
        t_single();
        t_nop();
        t_bcast();
        t_sleep_wake();
        t_ignore_sck();
        t_short();
        t_chain();
        t_clear();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule